// File: doc/BRIEF.md
# Bidirectional Serial-to-Parallel Segment Driver

This block converts a serial bit stream into a wide set of parallel segment drive levels for a liquid-crystal display. Bits enter through a serial input. On every cycle in which the shift strobe is high, they advance through a chain of stages. A direction select picks which end of the chain the bits enter at and which end feeds the cascade output, so several drivers can be daisy-chained in either orientation. A level-sensitive load enable passes the chain contents to the channel outputs while it is high and freezes them when it drops. Display data can therefore be streamed in behind a stable image.

Each channel output is the held bit XORed with a polarity input. The same polarity input also drives the common backplane output directly, so the whole panel can be AC-inverted without reloading data. A blank input, active low, forces every channel to the backplane level, which puts zero voltage across every segment. Everything runs in one system-clock domain: the shift clock is a one-cycle strobe, and all inputs arrive already synchronised.

Top module: `seg_serial_driver`

## Requirements
- R1: With `dir_up` = 1, a strobed cycle moves each stage k to stage k+1 and loads `ser_in` into stage 0. `cascade_o` shows stage N-1.
- R2: With `dir_up` = 0, a strobed cycle moves each stage k to stage k-1 and loads `ser_in` into stage N-1. `cascade_o` shows stage 0.
- R3: When `shift_stb` = 0 the chain keeps its contents. `latch_en`, `blank_n` and `pol` never change the chain.
- R4: While `latch_en` = 1, channel bit k follows chain stage k in the same cycle, with no added clock delay.
- R5: While `latch_en` = 0, the held value does not change. If the strobe and the load enable are both high at the same edge, the held value is the chain contents from before that shift.
- R6: With `blank_n` = 1, `seg_o[k]` equals the held bit k XOR `pol`.
- R7: `bp_o` equals `pol` combinationally, in every cycle.
- R8: With `blank_n` = 0, every bit of `seg_o` equals `pol`, whatever the held data.
- R9: A synchronous active-high `rst` clears the chain and the held value to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data input |
| shift_stb | input | 1 | One-cycle shift strobe |
| dir_up | input | 1 | 1: enter at stage 0 and shift upward; 0: enter at stage N-1 and shift downward |
| latch_en | input | 1 | Load enable: transparent while high, holds while low |
| blank_n | input | 1 | Blank, active low |
| pol | input | 1 | Polarity select |
| seg_o | output | NCH | Channel drive levels |
| bp_o | output | 1 | Backplane level |
| cascade_o | output | 1 | Last stage in the current direction |

## Verification
Bit-by-bit checks of the cascade output in both directions catch a chain that is wired the wrong way round or loads `ser_in` at the wrong end. A direction flip partway through a load is covered by the random phase. Cycles with the strobe and load enable high together show whether the held value was taken before or after the shift; a design that got this wrong would display data one stage off. Cycles with toggling load enable check for transparency without extra latency. Every combination of blank and polarity is tried, including blanking under high polarity. A design that forced blanked outputs low in that case would put DC across the panel.

// File: rtl/seg_drv_pkg.sv
package seg_drv_pkg;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} shift_dir_e;
endpackage

// File: rtl/seg_shift_chain.sv
module seg_shift_chain
  import seg_drv_pkg::*;
#(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ser_in,
  input  logic           shift_stb,
  input  logic           dir_up,
  output logic [NCH-1:0] chain_q,
  output logic           cascade_o
);
  localparam int TOP = NCH - 1;

  function automatic logic [NCH-1:0] chain_step(input logic [NCH-1:0] cur,
                                                input logic din,
                                                input shift_dir_e d);
    logic [NCH-1:0] nxt;
    if (d == DIR_UP) nxt = {cur[TOP-1:0], din};
    else             nxt = {din, cur[TOP:1]};
    return nxt;
  endfunction

  function automatic logic chain_tail(input logic [NCH-1:0] cur, input shift_dir_e d);
    return (d == DIR_UP) ? cur[TOP] : cur[0];
  endfunction

  shift_dir_e dir_sel;
  logic       shift_evt;
  logic [NCH-1:0] chain_next;

  assign dir_sel    = shift_dir_e'(dir_up);
  assign shift_evt  = shift_stb & ~rst;
  assign chain_next = chain_step(chain_q, ser_in, dir_sel);
  assign cascade_o  = chain_tail(chain_q, dir_sel);

  always_ff @(posedge clk) begin
    if (rst)            chain_q <= '0;
    else if (shift_stb) chain_q <= chain_next;
  end

  AST_CHAIN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !shift_stb |=> $stable(chain_q)); // R3
  AST_ENTRY_UP: assert property (@(posedge clk) disable iff (rst)
    (shift_evt && dir_up) |=> (chain_q[0] == $past(ser_in))); // R1
  AST_MOVE_UP: assert property (@(posedge clk) disable iff (rst)
    (shift_evt && dir_up) |=> (chain_q[TOP] == $past(chain_q[TOP-1]))); // R1
  AST_ENTRY_DOWN: assert property (@(posedge clk) disable iff (rst)
    (shift_evt && !dir_up) |=> (chain_q[TOP] == $past(ser_in))); // R2
  AST_MOVE_DOWN: assert property (@(posedge clk) disable iff (rst)
    (shift_evt && !dir_up) |=> (chain_q[0] == $past(chain_q[1]))); // R2
  AST_CHAIN_RESET: assert property (@(posedge clk)
    rst |=> (chain_q == '0)); // R9
endmodule

// File: rtl/seg_hold_bank.sv
module seg_hold_bank #(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           latch_en,
  input  logic [NCH-1:0] chain_q,
  output logic [NCH-1:0] held_o
);
  logic [NCH-1:0] hold_q;
  logic           capture_evt;

  assign capture_evt = latch_en & ~rst;

  always_ff @(posedge clk) begin
    if (rst)           hold_q <= '0;
    else if (latch_en) hold_q <= chain_q;
  end

  assign held_o = latch_en ? chain_q : hold_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !latch_en |=> $stable(hold_q)); // R5
  AST_HOLD_PRESHIFT: assert property (@(posedge clk) disable iff (rst)
    capture_evt |=> (hold_q == $past(chain_q))); // R5
  AST_HOLD_RESET: assert property (@(posedge clk)
    rst |=> (hold_q == '0)); // R9
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage #(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] held_i,
  input  logic           blank_n,
  input  logic           pol,
  output logic [NCH-1:0] seg_o,
  output logic           bp_o
);
  logic blank_evt;

  function automatic logic seg_level(input logic b, input logic p, input logic bl_n);
    return bl_n ? (b ^ p) : p;
  endfunction

  assign blank_evt = ~blank_n;
  assign bp_o      = pol;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign seg_o[k] = seg_level(held_i[k], pol, blank_n);
  end

  AST_BLANK_BP: assert property (@(posedge clk) disable iff (rst)
    blank_evt |-> (seg_o == {NCH{bp_o}})); // R8
  AST_POL_XOR: assert property (@(posedge clk) disable iff (rst)
    !blank_evt |-> ((seg_o ^ held_i) == {NCH{pol}})); // R6
  AST_BP_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    bp_o == pol); // R7
endmodule

// File: rtl/seg_serial_driver.sv
module seg_serial_driver #(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ser_in,
  input  logic           shift_stb,
  input  logic           dir_up,
  input  logic           latch_en,
  input  logic           blank_n,
  input  logic           pol,
  output logic [NCH-1:0] seg_o,
  output logic           bp_o,
  output logic           cascade_o
);
  logic [NCH-1:0] chain_q;
  logic [NCH-1:0] held;

  seg_shift_chain #(.NCH(NCH)) u_chain (
    .clk(clk), .rst(rst), .ser_in(ser_in), .shift_stb(shift_stb),
    .dir_up(dir_up), .chain_q(chain_q), .cascade_o(cascade_o)
  );

  seg_hold_bank #(.NCH(NCH)) u_hold (
    .clk(clk), .rst(rst), .latch_en(latch_en), .chain_q(chain_q), .held_o(held)
  );

  seg_out_stage #(.NCH(NCH)) u_out (
    .clk(clk), .rst(rst), .held_i(held), .blank_n(blank_n), .pol(pol),
    .seg_o(seg_o), .bp_o(bp_o)
  );

  AST_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
    (latch_en && blank_n && !pol) |-> (seg_o == chain_q)); // R4
endmodule

// File: tb/test_seg_serial_driver.sv
module test_seg_serial_driver;
  localparam int N = 32;
  logic clk = 1'b0;
  logic rst, ser_in, shift_stb, dir_up, latch_en, blank_n, pol;
  logic [N-1:0] seg_o;
  logic bp_o, cascade_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [N-1:0] m_chain = '0;
  logic [N-1:0] m_hold = '0;

  always #4 clk = ~clk;

  seg_serial_driver #(.NCH(N)) i_seg_serial_driver (
    .clk(clk), .rst(rst), .ser_in(ser_in), .shift_stb(shift_stb), .dir_up(dir_up),
    .latch_en(latch_en), .blank_n(blank_n), .pol(pol),
    .seg_o(seg_o), .bp_o(bp_o), .cascade_o(cascade_o)
  );

  function automatic logic [N-1:0] exp_seg(input logic [N-1:0] ch, input logic [N-1:0] hd,
                                           input logic le, input logic bl_n, input logic p);
    logic [N-1:0] v;
    v = le ? ch : hd;
    if (!bl_n) return {N{p}};
    return v ^ {N{p}};
  endfunction

  function automatic logic exp_tail(input logic [N-1:0] ch, input logic d);
    return d ? ch[N-1] : ch[0];
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic d, input logic s, input logic up,
                      input logic le, input logic bl_n, input logic p, input string tag);
    string stag;
    @(negedge clk);
    rst = r; ser_in = d; shift_stb = s; dir_up = up; latch_en = le; blank_n = bl_n; pol = p;
    #1;
    if (!bl_n) stag = "R8";
    else if (p) stag = "R6";
    else if (le) stag = "R4";
    else stag = "R5";
    chk(stag, seg_o, exp_seg(m_chain, m_hold, le, bl_n, p));
    chk("R7", {{(N-1){1'b0}}, bp_o}, {{(N-1){1'b0}}, p});
    chk(tag != "" ? tag : (up ? "R1" : "R2"), {{(N-1){1'b0}}, cascade_o},
        {{(N-1){1'b0}}, exp_tail(m_chain, up)});
    @(posedge clk);
    if (r) begin
      m_chain = '0; m_hold = '0;
    end else begin
      if (le) m_hold = m_chain;
      if (s) m_chain = up ? {m_chain[N-2:0], d} : {d, m_chain[N-1:1]};
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [N-1:0] pat;
    void'($urandom(32'h1F3A5C07));
    rst = 1'b1; ser_in = 0; shift_stb = 0; dir_up = 1; latch_en = 0; blank_n = 1; pol = 0;
    repeat (3) step(1, 1, 1, 1, 0, 1, 0, "R9");
    // R9: reset state visible through transparent load
    step(0, 0, 0, 1, 1, 1, 0, "R9");
    // R1: load upward, cascade checked every bit
    pat = 32'hC3A5_0F81;
    for (int i = 0; i < N; i++) step(0, pat[N-1-i], 1, 1, 0, 1, 0, "R1");
    step(0, 0, 0, 1, 1, 1, 0, "R4");
    // R3: idle with control inputs toggling, chain must not move
    for (int i = 0; i < 8; i++) step(0, 1, 0, i[0], 0, i[1], i[2], "R3");
    // R2: load downward with load enable toggling mid-stream (R5 pre-shift capture)
    pat = 32'h5E1D_77B2;
    for (int i = 0; i < N; i++) step(0, pat[i], 1, 0, (i % 5) == 2, 1, 0, "R2");
    // R6 R8: every blank/polarity combination over held data
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, i[0], i[1], "");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 1, i[0], i[1], "");
    // mid-run reset
    step(1, 0, 0, 1, 0, 1, 1, "R9");
    step(0, 0, 0, 1, 0, 1, 0, "R9");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      step(rv[7:0] == 8'd0, rv[1], rv[2] | rv[3], rv[12:9] != 4'd0,
           rv[6:4] == 3'd0, rv[8:7] != 2'd0, rv[13], "");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule